// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Classification

The block turns an asynchronous serial line back into data words. An external divider supplies a 16x oversampling tick. The line first passes a two-flop synchronizer. A receive state machine then finds each start bit, checks the start bit again at its midpoint and samples every later bit near the middle of its bit period.

The word length (5 to 8 bits) and the parity setting are the same ones the matching transmitter uses. Each completed frame is delivered once, on a one-cycle strobe, with its data and three flags: parity error, framing error and break. Break is kept separate from framing error.

The frame is also copied into a one-entry holding register. That register raises data-ready and, when a word arrives before the host has taken the previous one, raises overrun. A host read acknowledge empties it.

Top module: `async_rx`

## Requirements
- R1: A frame begins only at a falling edge of the synchronized line that follows the idle 1 level. After reset the receiver first waits until the line is 1, so a line that is 0 when reset releases produces no word.
- R2: The start bit is sampled again 8 ticks after it is detected. If the line is 1 at that point, the event is dropped: no word is delivered and the holding register is unchanged.
- R3: Data bits arrive least significant bit first. `cfg_len` selects the word length: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8. Bits above the configured length read 0. Start, parity and stop bits never appear in the data.
- R4: When `cfg_par_en` is 1, one parity bit follows the data, and `cfg_par_mode` sets the value it must have: 0 = even (data plus parity carries an even number of ones), 1 = odd, 2 = always 0, 3 = always 1. A mismatch sets the parity-error flag of that word.
- R5: A stop bit sampled as 0 sets the framing-error flag, and the data bits are still delivered. The receiver then waits for the line to return to 1 before it accepts another start.
- R6: If the line stays 0 from the start bit through the end of the stop bit, exactly one word is delivered: data 0, break flag 1, framing-error flag 0, parity-error flag 0. No further word is delivered until the line has returned to 1.
- R7: `frm_valid` is a one-cycle strobe that carries each word's data and flags. It is never high in two consecutive cycles.
- R8: `data_ready` rises only in the cycle after a word is delivered. A `rd_ack` with no word arriving clears both `data_ready` and `overrun` in the next cycle. If a word and `rd_ack` arrive in the same cycle, the new word is stored, `data_ready` stays 1 and `overrun` clears.
- R9: If a word arrives while `data_ready` is 1 and `rd_ack` is 0, `overrun` is set in the next cycle and the new word replaces the held one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | 16x oversampling tick, one cycle wide |
| rx_line | input | 1 | Asynchronous serial input line |
| cfg_len | input | 2 | Word length code (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_mode | input | 2 | Parity rule: even, odd, fixed 0, fixed 1 |
| rd_ack | input | 1 | Host read acknowledge for the holding register |
| frm_valid | output | 1 | One-cycle word strobe |
| frm_data | output | 8 | Received data, right aligned |
| frm_perr | output | 1 | Parity error flag of the strobed word |
| frm_ferr | output | 1 | Framing error flag of the strobed word |
| frm_brk | output | 1 | Break flag of the strobed word |
| hold_data | output | 8 | Data in the holding register |
| hold_perr | output | 1 | Held parity error flag |
| hold_ferr | output | 1 | Held framing error flag |
| hold_brk | output | 1 | Held break flag |
| data_ready | output | 1 | Holding register full |
| overrun | output | 1 | A word replaced an unread one |

## Verification
The line is driven with clean frames at every word length, and with alternating data values that show whether bits are ordered LSB first and whether the upper bits are masked. Parity frames cover each of the four rules, with both correct and wrong parity bits, so the parity-error flag is shown to follow the selected rule and not a fixed one. Error cases follow: a short low glitch, a frame whose stop bit is 0 but whose data is non-zero, and a long all-zero stretch. Together these separate a dropped start from a framing error and from a break. A line held at 0 across reset, followed by back-to-back unread frames and a late acknowledge, checks start arming, data-ready and overrun against a model that is updated on every clock.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  localparam int RX_DW   = 8;
  localparam int RX_OSR  = 16;
  localparam int RX_MINW = RX_DW - 3;

  typedef enum logic [2:0] {
    S_WAITHI, S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRKCHK
  } rx_state_t;

  typedef struct packed {
    logic [RX_DW-1:0] data;
    logic             perr;
    logic             ferr;
    logic             brk;
  } rx_word_t;

  // Value the parity bit must carry under a given rule.
  function automatic logic want_parity(input logic [RX_DW-1:0] d,
                                       input logic [1:0] mode);
    case (mode)
      2'd0:    return ^d;
      2'd1:    return ~(^d);
      2'd2:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import async_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       line,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic [1:0] cfg_par_mode,
  output logic       word_valid,
  output rx_word_t   word
);
  localparam int CW   = $clog2(RX_OSR);
  localparam int BW   = $clog2(RX_DW);
  localparam logic [CW-1:0] MID  = CW'(RX_OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(RX_OSR - 1);

  rx_state_t        state;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    idx;
  logic [RX_DW-1:0] shreg;
  logic             allz;
  logic             parbit;
  logic [BW-1:0]    last_idx;
  logic             perr_now;

  assign last_idx = BW'(RX_MINW - 1) + BW'(cfg_len);
  assign perr_now = cfg_par_en && (parbit != want_parity(shreg, cfg_par_mode));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_WAITHI;
      cnt        <= '0;
      idx        <= '0;
      shreg      <= '0;
      allz       <= 1'b0;
      parbit     <= 1'b0;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      word_valid <= 1'b0;
      if (tick) begin
        case (state)
          S_WAITHI: if (line) state <= S_IDLE;
          S_IDLE: begin
            if (!line) begin
              state <= S_START;
              cnt   <= '0;
            end
          end
          S_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              if (!line) begin
                state  <= S_DATA;
                idx    <= '0;
                shreg  <= '0;
                allz   <= 1'b1;
                parbit <= 1'b0;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (cnt == LAST) begin
              cnt        <= '0;
              shreg[idx] <= line;
              allz       <= allz & ~line;
              if (idx == last_idx) state <= cfg_par_en ? S_PAR : S_STOP;
              else                 idx   <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (cnt == LAST) begin
              cnt    <= '0;
              parbit <= line;
              allz   <= allz & ~line;
              state  <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (cnt == LAST) begin
              cnt <= '0;
              if (line) begin
                word_valid <= 1'b1;
                word       <= '{data: shreg, perr: perr_now, ferr: 1'b0, brk: 1'b0};
                state      <= S_IDLE;
              end else if (allz) begin
                state <= S_BRKCHK;
              end else begin
                word_valid <= 1'b1;
                word       <= '{data: shreg, perr: perr_now, ferr: 1'b1, brk: 1'b0};
                state      <= S_WAITHI;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_BRKCHK: begin
            if (line) begin
              word_valid <= 1'b1;
              word       <= '{data: shreg, perr: perr_now, ferr: 1'b1, brk: 1'b0};
              state      <= S_IDLE;
            end else if (cnt == MID) begin
              word_valid <= 1'b1;
              word       <= '{data: '0, perr: 1'b0, ferr: 1'b0, brk: 1'b1};
              state      <= S_WAITHI;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= S_WAITHI;
        endcase
      end
    end
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  // R6
  brk_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word.brk) |-> (word.data == '0 && !word.ferr && !word.perr));

  // R2
  glitch_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_START && tick && cnt == MID && line) |=> !word_valid);
endmodule

// File: rtl/rx_hold.sv
module rx_hold
  import async_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     in_valid,
  input  rx_word_t in_word,
  input  logic     rd_ack,
  output rx_word_t held,
  output logic     data_ready,
  output logic     overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held       <= '0;
      data_ready <= 1'b0;
      overrun    <= 1'b0;
    end else if (in_valid) begin
      held       <= in_word;
      data_ready <= 1'b1;
      if (data_ready && !rd_ack) overrun <= 1'b1;
      else if (rd_ack)           overrun <= 1'b0;
    end else if (rd_ack) begin
      data_ready <= 1'b0;
      overrun    <= 1'b0;
    end
  end

  // R8
  ready_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(data_ready) |-> $past(in_valid));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && !in_valid) |=> (!data_ready && !overrun));

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && data_ready && !rd_ack) |=> (overrun && data_ready));
endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             os_tick,
  input  logic             rx_line,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_en,
  input  logic [1:0]       cfg_par_mode,
  input  logic             rd_ack,
  output logic             frm_valid,
  output logic [RX_DW-1:0] frm_data,
  output logic             frm_perr,
  output logic             frm_ferr,
  output logic             frm_brk,
  output logic [RX_DW-1:0] hold_data,
  output logic             hold_perr,
  output logic             hold_ferr,
  output logic             hold_brk,
  output logic             data_ready,
  output logic             overrun
);
  logic     line_s;
  rx_word_t fword;
  rx_word_t hword;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rx_line),
    .q   (line_s)
  );

  rx_frame u_frame (
    .clk          (clk),
    .rst          (rst),
    .tick         (os_tick),
    .line         (line_s),
    .cfg_len      (cfg_len),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_mode (cfg_par_mode),
    .word_valid   (frm_valid),
    .word         (fword)
  );

  rx_hold u_hold (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (frm_valid),
    .in_word    (fword),
    .rd_ack     (rd_ack),
    .held       (hword),
    .data_ready (data_ready),
    .overrun    (overrun)
  );

  assign frm_data  = fword.data;
  assign frm_perr  = fword.perr;
  assign frm_ferr  = fword.ferr;
  assign frm_brk   = fword.brk;
  assign hold_data = hword.data;
  assign hold_perr = hword.perr;
  assign hold_ferr = hword.ferr;
  assign hold_brk  = hword.brk;
endmodule

// File: tb/async_rx_bench.sv
`timescale 1ns/1ps
module async_rx_bench;
  localparam int TDIV = 4;
  localparam int BITCLK = 16 * TDIV;

  typedef struct { logic [7:0] d; bit p; bit f; bit b; } exp_t;

  logic clk = 0, rst = 1, os_tick = 0, rx_line = 0, rd_ack = 0;
  logic [1:0] cfg_len = 2'd3, cfg_par_mode = 2'd0;
  logic cfg_par_en = 0;
  logic frm_valid, frm_perr, frm_ferr, frm_brk;
  logic [7:0] frm_data, hold_data;
  logic hold_perr, hold_ferr, hold_brk, data_ready, overrun;

  int checks = 0, fails = 0, cyc = 0, tdc = 0;
  exp_t exp_q[$];
  exp_t m_hold = '{8'h00, 0, 0, 0};
  bit m_dr = 0, m_ov = 0;

  always #2 clk = ~clk;

  async_rx u_async_rx (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_line(rx_line),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_mode(cfg_par_mode),
    .rd_ack(rd_ack), .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_perr(frm_perr), .frm_ferr(frm_ferr), .frm_brk(frm_brk),
    .hold_data(hold_data), .hold_perr(hold_perr), .hold_ferr(hold_ferr),
    .hold_brk(hold_brk), .data_ready(data_ready), .overrun(overrun));

  always @(posedge clk) begin
    tdc     <= (tdc == TDIV - 1) ? 0 : tdc + 1;
    os_tick <= (tdc == TDIV - 1);
    cyc     <= cyc + 1;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL all: watchdog expired, actual running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic bit par_of(logic [7:0] d, int mode);
    int ones = $countones(d);
    case (mode)
      0: return bit'(ones % 2);
      1: return bit'(1 - ones % 2);
      2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // Per-clock model of the holding register, then the word strobe.
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (data_ready !== m_dr || overrun !== m_ov ||
          (m_dr && (hold_data !== m_hold.d || hold_perr !== m_hold.p ||
                    hold_ferr !== m_hold.f || hold_brk !== m_hold.b))) begin
        fails++;
        $display("FAIL R8 R9 hold: actual dr=%0b ov=%0b d=%02h p%0b f%0b b%0b expected dr=%0b ov=%0b d=%02h p%0b f%0b b%0b",
                 data_ready, overrun, hold_data, hold_perr, hold_ferr, hold_brk,
                 m_dr, m_ov, m_hold.d, m_hold.p, m_hold.f, m_hold.b);
      end
      if (frm_valid) begin
        exp_t e;
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R1 R2 R6 R7: actual word %02h unexpected, expected none", frm_data);
          e = '{frm_data, frm_perr, frm_ferr, frm_brk};
        end else begin
          e = exp_q.pop_front();
          if (frm_data !== e.d || frm_perr !== e.p || frm_ferr !== e.f || frm_brk !== e.b) begin
            fails++;
            $display("FAIL R3 R4 R5 R6: actual d=%02h p%0b f%0b b%0b expected d=%02h p%0b f%0b b%0b",
                     frm_data, frm_perr, frm_ferr, frm_brk, e.d, e.p, e.f, e.b);
          end
        end
        if (m_dr && !rd_ack) m_ov = 1;
        else if (rd_ack)     m_ov = 0;
        m_dr = 1;
        m_hold = e;
      end else if (rd_ack) begin
        m_dr = 0;
        m_ov = 0;
      end
    end
  end

  task automatic bits(input int n);
    repeat (n * BITCLK) @(posedge clk);
    #1;
  endtask

  task automatic ack();
    @(posedge clk); #1 rd_ack = 1;
    @(posedge clk); #1 rd_ack = 0;
  endtask

  task automatic expect_empty(input string tag);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: actual %0d words missing, expected 0", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  // Sends one frame and queues the word the requirements call for.
  task automatic send(input logic [7:0] d, input bit pbit_ok, input bit sbit);
    int nb = 5 + cfg_len;
    logic [7:0] dm = d & ((8'd1 << nb) - 8'd1);
    bit pb = par_of(dm, cfg_par_mode);
    if (!pbit_ok) pb = ~pb;
    exp_q.push_back('{dm, cfg_par_en && !pbit_ok, !sbit, 1'b0});
    rx_line = 0; bits(1);
    for (int i = 0; i < nb; i++) begin rx_line = dm[i]; bits(1); end
    if (cfg_par_en) begin rx_line = pb; bits(1); end
    rx_line = sbit; bits(1);
    rx_line = 1; bits(2);
  endtask

  initial begin
    // R1: line low across reset, no word may come out
    repeat (5) @(posedge clk);
    #1 rst = 0;
    checks++;
    if (data_ready !== 0 || overrun !== 0 || frm_valid !== 0) begin
      fails++;
      $display("FAIL R8 reset: actual dr=%0b ov=%0b v=%0b expected 0 0 0", data_ready, overrun, frm_valid);
    end
    bits(3);
    rx_line = 1; bits(2);
    expect_empty("R1");

    // R3: 8 bits, LSB first
    cfg_len = 3; send(8'hA5, 1, 1); expect_empty("R3"); ack();
    send(8'h01, 1, 1); ack();
    // R3: 5 and 6 bits, upper bits masked
    cfg_len = 0; send(8'hF6, 1, 1); ack();
    cfg_len = 1; send(8'h2B, 1, 1); ack();
    expect_empty("R3");

    // R4: each parity rule, correct and wrong
    cfg_par_en = 1; cfg_len = 2;
    cfg_par_mode = 0; send(8'h53, 1, 1); send(8'h53, 0, 1); ack();
    cfg_par_mode = 1; send(8'h53, 1, 1); send(8'h22, 0, 1); ack();
    cfg_par_mode = 2; send(8'h7F, 1, 1); send(8'h7F, 0, 1); ack();
    cfg_par_mode = 3; send(8'h00, 1, 1); send(8'h10, 0, 1); ack();
    expect_empty("R4");
    cfg_par_en = 0; cfg_len = 3;

    // R2: short low glitch is dropped
    rx_line = 0; repeat (2 * TDIV) @(posedge clk); #1 rx_line = 1;
    bits(14);
    expect_empty("R2");

    // R5: stop bit low with data
    send(8'h3C, 1, 0); expect_empty("R5"); ack();

    // R6: long low line is one break word, then normal reception
    exp_q.push_back('{8'h00, 0, 0, 1});
    rx_line = 0; bits(25); rx_line = 1; bits(3);
    expect_empty("R6");
    ack();
    send(8'h81, 1, 1); expect_empty("R6 recovery");

    // R9: two unread words, then acknowledge clears
    send(8'h5A, 1, 1);
    send(8'hC3, 1, 1);
    expect_empty("R9");
    ack();
    bits(1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule